// File: doc/BRIEF.md
# Data Access Translation Fault Checker

This block sits between a load/store pipeline and a translation buffer. Each cycle it may accept one data access: a 64-bit virtual address, an access size, a store flag, several qualifiers (bypass translation, privileged code, alternate mode, page-table walk access), the current and alternate privilege modes, and the result of the translation buffer lookup that was already made for that address. One cycle later it returns the physical address, an uncacheable marker and, when the access cannot proceed, a one-hot fault code with a six-bit memory-management status vector.

The decision follows a fixed order: alignment, then the translation path (bypass, direct-mapped kernel window, or buffer entry with its per-mode permissions and trap-on-access bits), then the implemented-width check on the resulting physical address, and last the uncached I/O window. Translation storage and fault handling sit outside the block.

Top module: `dxlate_fault_chk`

## Requirements
- R1: A request accepted on a rising edge gives `rsp_valid` high after that edge and the results on the `rsp_*` outputs; with no request `rsp_valid` is low and the other outputs keep their last values; reset clears every output to zero.
- R2: An access whose address has any bit set in (size - 1), size being 1, 2, 4 or 8 bytes, raises the alignment fault (code bit 0) before any other check; its status holds only the store bit (status bit 5) for stores and is zero for loads.
- R3: The effective mode (0 kernel, 1 executive, 2 supervisor, 3 user) is the current mode, except for privileged code, where it is kernel, or the alternate mode when the alternate flag is also set.
- R4: With the bypass flag set, the physical address equals the virtual address and the buffer lookup inputs have no effect.
- R5: Without bypass, a virtual address whose bits 63:42 are not all equal raises the access-violation fault (code bit 1) with status store, violation (bit 4) and bad-address (bit 1).
- R6: Without bypass, an address with bits 47:41 equal to 7'h7E uses the direct window: outside kernel effective mode it raises the access-violation fault with status store and violation; in kernel mode the physical address is bits 43:0 of the virtual address, with bits 43:40 all ones when bit 40 is set and all zeros otherwise.
- R7: Otherwise a buffer miss raises the walk-miss fault (code bit 3) when the walk flag is set, else the native-miss fault (code bit 4); status holds the store bit and the miss bit (bit 0).
- R8: On a buffer hit the physical address is the page number shifted left by 13 plus virtual address bits 12:0.
- R9: A store whose effective-mode bit is clear in the entry's write-enable mask raises the access-violation fault with status store, violation and, when the entry's write trap is set, the write-trap bit (bit 3); a permitted store to an entry with the write trap set raises the trap fault (code bit 2) with status store and write-trap only.
- R10: A load whose effective-mode bit is clear in the read-enable mask raises the access-violation fault with status violation and, when the read trap is set, the read-trap bit (bit 2); a permitted load to an entry with the read trap set raises the trap fault with status read-trap only.
- R11: A translated address with any bit above bit 43 set raises the machine-check fault (code bit 5) with zero status.
- R12: A translated address with bit 43 set is uncacheable: if bits 43:36 are all ones it raises the unimplemented fault (code bit 6) with zero status, otherwise `rsp_uncached` is set and address bits 42:35 are cleared.
- R13: The fault code has at most one bit set; with no fault the status is zero, and with a fault the physical address and uncached marker are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | Access is a store |
| req_phys | input | 1 | Bypass translation |
| req_priv | input | 1 | Issued by privileged code |
| req_alt | input | 1 | Use the alternate mode when privileged |
| req_vpte | input | 1 | Access belongs to a page-table walk |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Buffer lookup found a matching entry |
| tlb_ppn | input | PPN_W | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables, bit index = mode |
| tlb_wr_en | input | 4 | Per-mode write enables, bit index = mode |
| tlb_rd_trap | input | 1 | Entry traps on read |
| tlb_wr_trap | input | 1 | Entry traps on write |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 44 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable and strictly ordered |
| rsp_fault | output | 7 | One-hot fault code, zero for none |
| rsp_status | output | 6 | {store, violation, write trap, read trap, bad address, miss} |

## Verification
The bench aims at the ordering of checks: a misaligned store with a bad address and no buffer hit must still report only alignment, and a design checking alignment late would report the address fault instead. It drives the direct window with bit 40 both set and clear, where a missing sign extension gives a wrong address or loses the uncached marking, and with privileged-but-alternate mode, where using the raw current mode grants or refuses the window wrongly. It hits permitted and denied stores and loads with traps set to catch swapped masks or a lost trap bit in the violation status, and pushes page numbers and bypass addresses past bit 43 and into the register window so that missing machine-check or unimplemented faults show up as wrong codes.

// File: rtl/dxf_pkg.sv
package dxf_pkg;
  localparam int VA_W = 64;
  localparam int PA_W = 44;
  localparam int FC_W = 7;
  localparam int ST_W = 6;

  localparam logic [1:0] MODE_KERN = 2'd0;

  // fault code bit positions
  localparam int FC_ALIGN = 0;
  localparam int FC_ACV   = 1;
  localparam int FC_TRAP  = 2;
  localparam int FC_PMISS = 3;
  localparam int FC_NMISS = 4;
  localparam int FC_MCHK  = 5;
  localparam int FC_UNIMP = 6;

  // status bit positions
  localparam int ST_MISS  = 0;
  localparam int ST_BADVA = 1;
  localparam int ST_RTRAP = 2;
  localparam int ST_WTRAP = 3;
  localparam int ST_ACV   = 4;
  localparam int ST_WR    = 5;

  // direct window and uncached space geometry
  localparam int       SP_HI     = 47;
  localparam int       SP_LO     = 41;
  localparam logic [6:0] SP_TAG  = 7'h7E;
  localparam int       CANON_LO  = 42;
  localparam int       SIGNX_BIT = 40;
  localparam int       UNC_BIT   = 43;
  localparam int       CLR_HI    = 42;
  localparam int       CLR_LO    = 35;
  localparam int       REG_LO    = 36;

  function automatic logic misaligned(logic [3:0] va_lo, logic [3:0] size);
    return |(va_lo & (size - 4'd1));
  endfunction

  function automatic logic va_canonical(logic [VA_W-1:0] va);
    return (&va[VA_W-1:CANON_LO]) | ~(|va[VA_W-1:CANON_LO]);
  endfunction

  function automatic logic in_window(logic [VA_W-1:0] va);
    return va[SP_HI:SP_LO] == SP_TAG;
  endfunction

  function automatic logic [VA_W-1:0] window_pa(logic [VA_W-1:0] va);
    logic [VA_W-1:0] p;
    p = '0;
    p[PA_W-1:0] = va[PA_W-1:0];
    if (p[SIGNX_BIT]) p[PA_W-1:SIGNX_BIT] = '1;
    else              p[PA_W-1:SIGNX_BIT] = '0;
    return p;
  endfunction

  function automatic logic [VA_W-1:0] page_pa(logic [VA_W-1:0] ppn64,
                                               logic [VA_W-1:0] va,
                                               int shift);
    logic [VA_W-1:0] off_mask;
    off_mask = (64'd1 << shift) - 64'd1;
    return (ppn64 << shift) + (va & off_mask);
  endfunction

  function automatic logic [PA_W-1:0] strip_uncached(logic [PA_W-1:0] pa);
    logic [PA_W-1:0] q;
    q = pa;
    q[CLR_HI:CLR_LO] = '0;
    return q;
  endfunction
endpackage

// File: rtl/dxf_mode_sel.sv
module dxf_mode_sel (
  input  logic       priv,
  input  logic       alt,
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  output logic [1:0] eff_mode
);
  import dxf_pkg::*;

  always_comb begin
    if (priv) eff_mode = alt ? alt_mode : MODE_KERN;
    else      eff_mode = cur_mode;
  end
endmodule

// File: rtl/dxf_xlate.sv
module dxf_xlate #(
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic [63:0]          va,
  input  logic                 write,
  input  logic                 phys,
  input  logic                 vpte,
  input  logic [1:0]           eff_mode,
  input  logic                 hit,
  input  logic [PPN_W-1:0]     ppn,
  input  logic [3:0]           rd_en,
  input  logic [3:0]           wr_en,
  input  logic                 rd_trap,
  input  logic                 wr_trap,
  output logic [63:0]          path_pa,
  output logic [6:0]           path_code,
  output logic [5:0]           path_stat,
  output logic                 ev_window,
  output logic                 ev_lookup
);
  import dxf_pkg::*;

  localparam int PAD_W = VA_W - PPN_W;

  logic [VA_W-1:0] ppn64;
  logic            mode_rd_ok;
  logic            mode_wr_ok;

  assign ppn64      = {{PAD_W{1'b0}}, ppn};
  assign mode_rd_ok = rd_en[eff_mode];
  assign mode_wr_ok = wr_en[eff_mode];

  always_comb begin
    path_pa   = va;
    path_code = '0;
    path_stat = '0;
    ev_window = 1'b0;
    ev_lookup = 1'b0;
    if (!phys) begin
      if (!va_canonical(va)) begin
        path_code[FC_ACV]  = 1'b1;
        path_stat[ST_WR]   = write;
        path_stat[ST_ACV]  = 1'b1;
        path_stat[ST_BADVA] = 1'b1;
      end else if (in_window(va)) begin
        ev_window = 1'b1;
        if (eff_mode != MODE_KERN) begin
          path_code[FC_ACV] = 1'b1;
          path_stat[ST_WR]  = write;
          path_stat[ST_ACV] = 1'b1;
        end else begin
          path_pa = window_pa(va);
        end
      end else begin
        ev_lookup = 1'b1;
        if (!hit) begin
          if (vpte) path_code[FC_PMISS] = 1'b1;
          else      path_code[FC_NMISS] = 1'b1;
          path_stat[ST_WR]   = write;
          path_stat[ST_MISS] = 1'b1;
        end else begin
          path_pa = page_pa(ppn64, va, PAGE_SHIFT);
          if (write) begin
            if (!mode_wr_ok) begin
              path_code[FC_ACV]   = 1'b1;
              path_stat[ST_WR]    = 1'b1;
              path_stat[ST_ACV]   = 1'b1;
              path_stat[ST_WTRAP] = wr_trap;
            end else if (wr_trap) begin
              path_code[FC_TRAP]  = 1'b1;
              path_stat[ST_WR]    = 1'b1;
              path_stat[ST_WTRAP] = 1'b1;
            end
          end else begin
            if (!mode_rd_ok) begin
              path_code[FC_ACV]   = 1'b1;
              path_stat[ST_ACV]   = 1'b1;
              path_stat[ST_RTRAP] = rd_trap;
            end else if (rd_trap) begin
              path_code[FC_TRAP]  = 1'b1;
              path_stat[ST_RTRAP] = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dxf_resolve.sv
module dxf_resolve (
  input  logic        align_bad,
  input  logic        write,
  input  logic [63:0] path_pa,
  input  logic [6:0]  path_code,
  input  logic [5:0]  path_stat,
  output logic [43:0] fin_pa,
  output logic        fin_unc,
  output logic [6:0]  fin_code,
  output logic [5:0]  fin_stat,
  output logic        ev_mchk,
  output logic        ev_regspace
);
  import dxf_pkg::*;

  logic [PA_W-1:0] pa_lo;

  assign pa_lo       = path_pa[PA_W-1:0];
  assign ev_mchk     = |path_pa[VA_W-1:PA_W];
  assign ev_regspace = &pa_lo[PA_W-1:REG_LO];

  always_comb begin
    fin_pa   = '0;
    fin_unc  = 1'b0;
    fin_code = '0;
    fin_stat = '0;
    if (align_bad) begin
      fin_code[FC_ALIGN] = 1'b1;
      fin_stat[ST_WR]    = write;
    end else if (|path_code) begin
      fin_code = path_code;
      fin_stat = path_stat;
    end else if (ev_mchk) begin
      fin_code[FC_MCHK] = 1'b1;
    end else if (pa_lo[UNC_BIT]) begin
      if (ev_regspace) begin
        fin_code[FC_UNIMP] = 1'b1;
      end else begin
        fin_unc = 1'b1;
        fin_pa  = strip_uncached(pa_lo);
      end
    end else begin
      fin_pa = pa_lo;
    end
  end
endmodule

// File: rtl/dxlate_fault_chk.sv
module dxlate_fault_chk #(
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_vaddr,
  input  logic [3:0]        req_size,
  input  logic              req_write,
  input  logic              req_phys,
  input  logic              req_priv,
  input  logic              req_alt,
  input  logic              req_vpte,
  input  logic [1:0]        cur_mode,
  input  logic [1:0]        alt_mode,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [3:0]        tlb_rd_en,
  input  logic [3:0]        tlb_wr_en,
  input  logic              tlb_rd_trap,
  input  logic              tlb_wr_trap,
  output logic              rsp_valid,
  output logic [43:0]       rsp_paddr,
  output logic              rsp_uncached,
  output logic [6:0]        rsp_fault,
  output logic [5:0]        rsp_status
);
  import dxf_pkg::*;

  logic [1:0]  eff_mode;
  logic        align_bad;
  logic [63:0] path_pa;
  logic [6:0]  path_code;
  logic [5:0]  path_stat;
  logic        ev_window;
  logic        ev_lookup;
  logic [43:0] fin_pa;
  logic        fin_unc;
  logic [6:0]  fin_code;
  logic [5:0]  fin_stat;
  logic        ev_mchk;
  logic        ev_regspace;

  assign align_bad = misaligned(req_vaddr[3:0], req_size);

  dxf_mode_sel u_mode (
    .priv     (req_priv),
    .alt      (req_alt),
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .eff_mode (eff_mode)
  );

  dxf_xlate #(.PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_xlate (
    .va        (req_vaddr),
    .write     (req_write),
    .phys      (req_phys),
    .vpte      (req_vpte),
    .eff_mode  (eff_mode),
    .hit       (tlb_hit),
    .ppn       (tlb_ppn),
    .rd_en     (tlb_rd_en),
    .wr_en     (tlb_wr_en),
    .rd_trap   (tlb_rd_trap),
    .wr_trap   (tlb_wr_trap),
    .path_pa   (path_pa),
    .path_code (path_code),
    .path_stat (path_stat),
    .ev_window (ev_window),
    .ev_lookup (ev_lookup)
  );

  dxf_resolve u_resolve (
    .align_bad   (align_bad),
    .write       (req_write),
    .path_pa     (path_pa),
    .path_code   (path_code),
    .path_stat   (path_stat),
    .fin_pa      (fin_pa),
    .fin_unc     (fin_unc),
    .fin_code    (fin_code),
    .fin_stat    (fin_stat),
    .ev_mchk     (ev_mchk),
    .ev_regspace (ev_regspace)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= '0;
      rsp_status   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr    <= fin_pa;
        rsp_uncached <= fin_unc;
        rsp_fault    <= fin_code;
        rsp_status   <= fin_stat;
      end
    end
  end
endmodule

// File: rtl/dxf_checker.sv
module dxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_phys,
  input logic        align_bad,
  input logic        ev_window,
  input logic [1:0]  eff_mode,
  input logic        rsp_valid,
  input logic [43:0] rsp_paddr,
  input logic        rsp_uncached,
  input logic [6:0]  rsp_fault,
  input logic [5:0]  rsp_status
);
  import dxf_pkg::*;

  assert_valid_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr));

  assert_align_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && align_bad |=> rsp_fault == 7'b0000001 && rsp_status[4:0] == 5'b0);

  assert_bypass_no_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_phys |=> !rsp_fault[FC_ACV] && !rsp_fault[FC_TRAP]
                            && !rsp_fault[FC_PMISS] && !rsp_fault[FC_NMISS]);

  assert_window_kernel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !align_bad && ev_window && eff_mode != MODE_KERN |=> rsp_fault[FC_ACV]);

  assert_miss_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault[FC_PMISS] || rsp_fault[FC_NMISS])
      |-> rsp_status[ST_MISS] && rsp_status[4:1] == 4'b0);

  assert_uncached_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncached |-> rsp_fault == 7'b0 && rsp_paddr[43] && rsp_paddr[42:35] == 8'b0);

  assert_code_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_fault));

  assert_clean_ok_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 7'b0 |-> rsp_status == 6'b0);
endmodule

bind dxlate_fault_chk dxf_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_phys     (req_phys),
  .align_bad    (align_bad),
  .ev_window    (ev_window),
  .eff_mode     (eff_mode),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_uncached (rsp_uncached),
  .rsp_fault    (rsp_fault),
  .rsp_status   (rsp_status)
);

// File: tb/dxlate_fault_chk_test.sv
module dxlate_fault_chk_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [3:0]  req_size = 4'd1;
  logic        req_write = 1'b0;
  logic        req_phys = 1'b0;
  logic        req_priv = 1'b0;
  logic        req_alt = 1'b0;
  logic        req_vpte = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic [1:0]  alt_mode = '0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0;
  logic [3:0]  tlb_wr_en = '0;
  logic        tlb_rd_trap = 1'b0;
  logic        tlb_wr_trap = 1'b0;
  logic        rsp_valid;
  logic [43:0] rsp_paddr;
  logic        rsp_uncached;
  logic [6:0]  rsp_fault;
  logic [5:0]  rsp_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxlate_fault_chk uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
    .req_priv(req_priv), .req_alt(req_alt), .req_vpte(req_vpte),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_rd_trap(tlb_rd_trap), .tlb_wr_trap(tlb_wr_trap),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status)
  );

  // Reference: fault codes 1 align, 2 violation, 4 trap, 8 walk miss,
  // 16 native miss, 32 machine check, 64 unimplemented.
  // Status: 32 store, 16 violation, 8 write trap, 4 read trap, 2 bad addr, 1 miss.
  function automatic void model(output logic [6:0] fc, output logic [5:0] st,
                                output logic [43:0] pa, output logic unc);
    logic [63:0] p;
    logic [1:0]  m;
    logic [21:0] top;
    logic        ok;
    logic [5:0]  wb;
    fc = 0; st = 0; pa = 0; unc = 0;
    wb = req_write ? 6'd32 : 6'd0;
    if ((req_vaddr % {60'd0, req_size}) != 64'd0) begin
      fc = 7'd1; st = wb; return;
    end
    m = req_priv ? (req_alt ? alt_mode : 2'd0) : cur_mode;
    if (req_phys) begin
      p = req_vaddr;
    end else begin
      top = req_vaddr[63:42];
      if (top != 22'd0 && top != 22'h3FFFFF) begin
        fc = 7'd2; st = wb | 6'd16 | 6'd2; return;
      end
      if (((req_vaddr >> 41) & 64'h7F) == 64'h7E) begin
        if (m != 2'd0) begin fc = 7'd2; st = wb | 6'd16; return; end
        p = req_vaddr & 64'hFFF_FFFF_FFFF;
        if (p[40]) p = p | 64'hF00_0000_0000;
        else       p = p & 64'h0FF_FFFF_FFFF;
      end else begin
        if (!tlb_hit) begin
          fc = req_vpte ? 7'd8 : 7'd16; st = wb | 6'd1; return;
        end
        p = {32'd0, tlb_ppn} * 64'd8192 + (req_vaddr % 64'd8192);
        if (req_write) begin
          ok = tlb_wr_en[m];
          if (!ok) begin fc = 7'd2; st = 6'd48 | (tlb_wr_trap ? 6'd8 : 6'd0); return; end
          if (tlb_wr_trap) begin fc = 7'd4; st = 6'd40; return; end
        end else begin
          ok = tlb_rd_en[m];
          if (!ok) begin fc = 7'd2; st = 6'd16 | (tlb_rd_trap ? 6'd4 : 6'd0); return; end
          if (tlb_rd_trap) begin fc = 7'd4; st = 6'd4; return; end
        end
      end
    end
    if ((p >> 44) != 64'd0) begin fc = 7'd32; return; end
    if (p[43]) begin
      if (p[43:36] == 8'hFF) begin fc = 7'd64; return; end
      unc = 1'b1;
      p = p & ~(64'hFF << 35);
    end
    pa = p[43:0];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  logic [6:0]  e_fc;
  logic [5:0]  e_st;
  logic [43:0] e_pa;
  logic        e_unc;

  task automatic run(input string tag);
    req_valid = 1'b1;
    model(e_fc, e_st, e_pa, e_unc);
    @(negedge clk);
    check(tag, "valid",  {63'd0, rsp_valid}, 64'd1);
    check(tag, "fault",  {57'd0, rsp_fault}, {57'd0, e_fc});
    check(tag, "status", {58'd0, rsp_status}, {58'd0, e_st});
    check(tag, "paddr",  {20'd0, rsp_paddr}, {20'd0, e_pa});
    check(tag, "uncached", {63'd0, rsp_uncached}, {63'd0, e_unc});
    check("R13", "onehot", {63'd0, ($countones(rsp_fault) <= 1)}, 64'd1);
  endtask

  task automatic base_load(input logic [63:0] va);
    req_vaddr = va; req_size = 4'd8; req_write = 0; req_phys = 0;
    req_priv = 0; req_alt = 0; req_vpte = 0; cur_mode = 2'd0; alt_mode = 2'd0;
    tlb_hit = 1; tlb_ppn = 32'h0001_2345; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;
    tlb_rd_trap = 0; tlb_wr_trap = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "reset valid", {63'd0, rsp_valid}, 64'd0);
    check("R1", "reset fault", {57'd0, rsp_fault}, 64'd0);
    check("R1", "reset paddr", {20'd0, rsp_paddr}, 64'd0);
    rst_n = 1'b1;

    // R2: misaligned store with bad address and miss still reports alignment
    base_load(64'h1234_0000_0000_0006); req_size = 4'd4; req_write = 1; tlb_hit = 0;
    run("R2");
    base_load(64'h0000_0000_0000_1001); req_size = 4'd2; run("R2");
    // R4: bypass ignores lookup inputs
    base_load(64'h0000_0123_4567_8000); req_phys = 1; tlb_hit = 0; run("R4");
    tlb_hit = 1; tlb_rd_en = 0; tlb_rd_trap = 1; run("R4");
    // R11: bypass above implemented width, and large page number
    base_load(64'h0004_0000_0000_0000); req_phys = 1; run("R11");
    base_load(64'h0000_0000_0000_2000); tlb_ppn = 32'h8000_0000; run("R11");
    // R5: bad address
    base_load(64'h0000_0800_0000_0000); req_write = 1; run("R5");
    // R6: window in user mode, kernel with bit 40 clear and set
    base_load(64'hFFFF_FC00_1234_5678); cur_mode = 2'd3; run("R6");
    base_load(64'hFFFF_FC00_1234_5678); run("R6");
    base_load(64'hFFFF_FD12_3456_7800); run("R6");
    // R3: privileged forces kernel; privileged alternate uses alternate mode
    base_load(64'hFFFF_FC00_0000_0040); cur_mode = 2'd3; req_priv = 1; run("R3");
    req_alt = 1; alt_mode = 2'd2; run("R3");
    base_load(64'h0000_0000_0000_4000); cur_mode = 2'd3; tlb_rd_en = 4'b1000; run("R3");
    req_priv = 1; run("R3");
    // R7: misses
    base_load(64'h0000_0000_0001_0000); tlb_hit = 0; req_vpte = 1; run("R7");
    req_vpte = 0; req_write = 1; run("R7");
    // R8: hit translation
    base_load(64'h0000_0000_0003_5ab8); run("R8");
    // R9: stores
    base_load(64'h0000_0000_0003_0008); req_write = 1; cur_mode = 2'd2;
    tlb_wr_en = 4'b1011; tlb_wr_trap = 1; run("R9");
    tlb_wr_en = 4'b0100; run("R9");
    tlb_wr_trap = 0; tlb_rd_en = 0; run("R9");
    // R10: loads
    base_load(64'h0000_0000_0003_0010); cur_mode = 2'd1; tlb_rd_en = 4'b1101;
    tlb_rd_trap = 1; run("R10");
    tlb_rd_en = 4'b0010; run("R10");
    tlb_rd_trap = 0; tlb_wr_en = 0; run("R10");
    // R12: uncached window and register space
    base_load(64'h0000_0000_0000_0000); tlb_ppn = 32'h4123_4567; run("R12");
    base_load(64'hFFFF_FDF0_0000_0100); run("R12");
    // R1: idle cycle holds outputs
    req_valid = 1'b0; req_vaddr = 64'h0000_0000_0000_7777;
    @(negedge clk);
    check("R1", "idle valid", {63'd0, rsp_valid}, 64'd0);
    check("R1", "idle hold fault", {57'd0, rsp_fault}, {57'd0, e_fc});
    check("R1", "idle hold paddr", {20'd0, rsp_paddr}, {20'd0, e_pa});

    for (int i = 0; i < 3000; i++) begin
      int cls;
      logic [63:0] va;
      cls = $urandom_range(0, 3);
      va = {$urandom, $urandom};
      case (cls)
        0: if ($urandom_range(0, 3) != 0) va[63:44] = '0;
        1: va[63:41] = {22'h3FFFFF, 1'b0};
        2: va[63:42] = ($urandom_range(0, 1) != 0) ? 22'h3FFFFF : 22'd0;
        default: ;
      endcase
      req_size = 4'd1 << $urandom_range(0, 3);
      if ($urandom_range(0, 7) != 0) va[3:0] = va[3:0] & ~(req_size - 4'd1);
      req_vaddr = va;
      req_phys = (cls == 0);
      req_write = $urandom_range(0, 1);
      req_priv = ($urandom_range(0, 3) == 0);
      req_alt = $urandom_range(0, 1);
      req_vpte = $urandom_range(0, 1);
      cur_mode = $urandom_range(0, 3);
      alt_mode = $urandom_range(0, 3);
      tlb_hit = ($urandom_range(0, 3) != 0);
      tlb_ppn = $urandom;
      if ($urandom_range(0, 7) != 0) tlb_ppn[31] = 1'b0;
      tlb_rd_en = $urandom_range(0, 15);
      tlb_wr_en = $urandom_range(0, 15);
      tlb_rd_trap = ($urandom_range(0, 3) == 0);
      tlb_wr_trap = ($urandom_range(0, 3) == 0);
      run("random");
      if ($urandom_range(0, 9) == 0) begin
        req_valid = 1'b0;
        @(negedge clk);
        check("R1", "random idle", {63'd0, rsp_valid}, 64'd0);
      end
    end

    req_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule